// File: doc/BRIEF.md
# Iterative Triangular-Sum Engine

The block adds up the integers from 1 to an unsigned 4-bit operand and reports the result on an 8-bit output. It does not compute the result with a closed-form expression. A small datapath holds three parts:

- a result accumulator with a synchronous clear and a write enable;
- a loadable down-counter that has a zero flag;
- an adder that adds the zero-extended counter value to the accumulator.

A six-state sequencer drives these parts. It first clears the accumulator and captures the operand into the counter. It then alternates between an accumulate step and a decrement step until the counter reaches zero. Finally it raises a completion flag.

A requester drives the operand, raises `go`, and waits for `finished`. The result on `total` is valid while `finished` is high. The engine holds `finished` and the result until `go` is released. It then returns to idle, and the accumulator is cleared again there. The counter value and the capture strobe are also visible at the ports, for observation.

Top module: `tri_accum`

## Requirements
- R1: While `rst_n` is low, `total` reads 0 and `finished` and `grab` read 0. After `rst_n` is released, the engine idles until `go` is sampled high.
- R2: While idle with `go` low, `finished` and `grab` stay 0 and `total` stays 0, for any number of cycles.
- R3: `grab` is high for exactly one cycle, the cycle after the edge that samples `go` high. On the next edge the counter captures the operand, so `cnt_now` equals the operand in the cycle that follows.
- R4: When `finished` is high, `total` equals k(k+1)/2 for the operand k captured at the start of that run. This holds for every k from 0 to 15: k = 0 gives 0 and k = 15 gives 120.
- R5: `finished` rises exactly 2k+5 rising edges after the edge that samples `go` high. That edge counts as edge 1 of the run.
- R6: `finished` stays high as long as `go` stays high. One edge after `go` is sampled low, the engine is idle and `finished` reads 0.
- R7: One edge after the engine returns to idle, `total` reads 0. The result of the previous run therefore never carries into the next run.
- R8: Changing the operand after the counter has captured it has no effect on the result of the run in progress.
- R9: `total` does not change while `finished` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Starts a run when sampled high in idle; holding it high keeps the result presented |
| opnd | input | 4 | Unsigned operand k |
| total | output | 8 | Accumulated sum |
| cnt_now | output | 4 | Current down-counter value |
| grab | output | 1 | High in the cycle in which the operand is captured |
| finished | output | 1 | High while the result is presented |

## Verification
The edge that samples `go` is edge 1 of a run. `grab` is due after edge 1, `cnt_now` shows the operand after edge 2, and `finished` together with the sum is due after edge 2k+5. After `go` drops, `finished` must be low one edge later and `total` must be zero one edge after that. The bench counts rising edges in its own counter. The driver records the edge count at which it raises `go` and pushes the expected sum and due edge into a queue. The monitor samples on falling edges and, when `finished` rises, compares both the value and the exact edge. The capture, release and clear checks are made at falling edges whose position is fixed relative to the recorded start edge.

// File: rtl/tri_accum.sv
module tri_accum #(
  parameter int N_W = 4,
  parameter int S_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] opnd,
  output logic [S_W-1:0] total,
  output logic [N_W-1:0] cnt_now,
  output logic           grab,
  output logic           finished
);
  localparam int PAD = S_W - N_W;

  typedef enum logic [2:0] {
    IDLE  = 3'd0,
    LATCH = 3'd1,
    PRIME = 3'd2,
    ADD   = 3'd3,
    STEP  = 3'd4,
    FIN   = 3'd5
  } st_t;

  st_t st, st_nx;
  logic clr, acc_we, cnt_dec, zero;
  logic [N_W-1:0] cnt;
  logic [S_W-1:0] acc, addend;

  assign clr      = (st == IDLE) || (st == LATCH) || (st == PRIME);
  assign grab     = (st == LATCH);
  assign acc_we   = (st == ADD);
  assign cnt_dec  = (st == STEP);
  assign finished = (st == FIN);
  assign zero     = (cnt == '0);
  assign addend   = {{PAD{1'b0}}, cnt} + acc;
  assign total    = acc;
  assign cnt_now  = cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc <= '0;
    else if (clr)     acc <= '0;
    else if (acc_we)  acc <= addend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (grab)    cnt <= opnd;
    else if (cnt_dec) cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else        st <= st_nx;

  always_comb begin
    st_nx = IDLE;
    case (st)
      IDLE:  st_nx = go ? LATCH : IDLE;
      LATCH: st_nx = PRIME;
      PRIME: st_nx = ADD;
      ADD:   st_nx = STEP;
      STEP:  st_nx = zero ? FIN : ADD;
      FIN:   st_nx = go ? FIN : IDLE;
      default: st_nx = IDLE;
    endcase
  end
endmodule

// File: rtl/tri_accum_chk.sv
module tri_accum_chk #(
  parameter int N_W = 4,
  parameter int S_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic [N_W-1:0] opnd,
  input logic [S_W-1:0] total,
  input logic [N_W-1:0] cnt_now,
  input logic           grab,
  input logic           finished
);
  a_r3_grab_single: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> !grab);

  a_r3_cnt_captures: assert property (@(posedge clk) disable iff (!rst_n)
    grab |=> (cnt_now == $past(opnd)));

  a_r6_no_grab_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !grab);

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && go) |=> finished);

  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !go) |=> !finished);

  a_r9_total_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && $past(finished)) |-> $stable(total));

  a_r7_clear_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(finished) |=> (total == '0));
endmodule

bind tri_accum tri_accum_chk #(.N_W(N_W), .S_W(S_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .opnd(opnd), .total(total),
  .cnt_now(cnt_now), .grab(grab), .finished(finished)
);

// File: tb/sim_tri_accum.sv
module sim_tri_accum;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [3:0] opnd = '0;
  logic [7:0] total;
  logic [3:0] cnt_now;
  logic grab, finished;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int exp_sum_q[$];
  int due_q[$];
  bit prev_fin = 1'b0;

  tri_accum u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .opnd(opnd), .total(total),
    .cnt_now(cnt_now), .grab(grab), .finished(finished)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (finished && !prev_fin) begin
        if (exp_sum_q.size() == 0) chk("R5 unexpected finish", 1, 0);
        else begin
          int es, due;
          es  = exp_sum_q.pop_front();
          due = due_q.pop_front();
          chk("R4 total", total, es);
          chk("R5 finish edge", edges, due);
        end
      end
      prev_fin = finished;
    end else prev_fin = 1'b0;
  end

  task automatic run(input int k, input bit perturb);
    int t0;
    @(negedge clk);
    opnd = 4'(k);
    go = 1'b1;
    t0 = edges;
    exp_sum_q.push_back(k * (k + 1) / 2);
    due_q.push_back(t0 + 2 * k + 5);
    @(negedge clk);
    chk("R3 grab after start", grab, 1);
    @(negedge clk);
    chk("R3 grab single", grab, 0);
    chk("R3 cnt captured", cnt_now, k);
    if (perturb) opnd = ~4'(k);
    while (!finished) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk("R6 finish held", finished, 1);
      chk("R9 total held", total, k * (k + 1) / 2);
    end
    go = 1'b0;
    @(negedge clk);
    chk("R6 finish released", finished, 0);
    @(negedge clk);
    chk("R7 total cleared", total, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset total", total, 0);
    chk("R1 reset finished", finished, 0);
    chk("R1 reset grab", grab, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R2 idle finished", finished, 0);
      chk("R2 idle grab", grab, 0);
      chk("R2 idle total", total, 0);
    end
    run(0, 1'b0);
    run(15, 1'b0);
    for (int k = 1; k < 15; k++) run(k, 1'b0);
    run(6, 1'b1);   // R8: operand flipped after capture
    run(15, 1'b1);  // R8
    @(negedge clk);
    chk("R5 queue drained", exp_sum_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule